// File: doc/BRIEF.md
# Four-wire serial programming port

This block is the device side of a serial port through which an external programmer reads and writes on-chip nonvolatile storage: the program store, the data store and the start-up configuration registers. The programmer holds a mode pin high to open a session, then clocks in 32-bit frames most significant bit first on a serial clock and data pin. Each finished frame becomes one read or one write request on a simple request/acknowledge port facing the memory controller. That controller also reports, through a busy level, a write that is still in progress.

The single serial output pin has two meanings, chosen by the direction of the last frame that was accepted. After a write it reports readiness: low while the store is occupied, high once the next frame may be sent. After a read it returns the fetched byte during the data positions of the next frame. All three input pins come from outside the system clock domain. They are synchronized first, and every pin edge is detected on the system clock.

Top module: `serprog_port`

## Requirements
- R1: With the mode pin low, and after reset, the serial output is low, no memory request is raised and the bit counter is cleared.
- R2: A frame is 32 bits, first bit sent is bit 31; bits 31..24 are the command, 23..8 the address and 7..0 the write data. After the 32nd sampled rising clock edge, exactly one request carries that address and data.
- R3: Command bit 31 selects write (1) or read (0). Bits 25..24 select the target: 00 program store, 01 data store, 10 configuration registers. Target 11, or any of bits 30..26 set, gives no request and leaves the output mode unchanged.
- R4: A raised request keeps its direction, target, address and data stable until acknowledge is sampled high, and it drops in the next cycle.
- R5: In write mode, while the serial clock is low, the output is low when a request is outstanding or the store reports busy. Otherwise it is high.
- R6: In read mode, the output is low outside the data field of the next frame. Before the host samples on rising edges 25 to 32 it carries the fetched byte, bit 7 first. Each bit is updated after the preceding falling edge.
- R7: Dropping the mode pin in the middle of a frame discards the partial bits. The next session starts a fresh frame at bit 31.
- R8: When the mode pin falls together with the 32nd rising clock edge, the abort wins and the frame is discarded.
- R9: A frame that completes while a request is outstanding or the store is busy is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_load | input | 1 | Mode pin, high opens a programming session (asynchronous) |
| prog_clk | input | 1 | Serial clock from the programmer (asynchronous) |
| prog_din | input | 1 | Serial data in, sampled on rising serial clock |
| prog_dout | output | 1 | Serial data out: ready status or read byte |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request direction, 1 = write |
| mem_tgt | output | 2 | Target store select |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 8 | Read data, valid with acknowledge |
| mem_busy | input | 1 | Write still in progress after acknowledge |

## Verification
Two things can land in the same system cycle: the mode pin falling, which aborts, and the 32nd rising serial edge, which completes a frame. Both pins pass through synchronizers of the same depth, so the bench switches them at one instant after 31 clean bits. The test passes only if no request follows and a later full frame is decoded cleanly. A second overlap, a new frame finishing while the store is still busy, is provoked by lengthening the modelled busy time past a whole frame. The scoreboard then finds that request missing from the queue.

// File: rtl/serprog_pkg.sv
// Shared widths and target encoding for the serial programming port.
package serprog_pkg;
    parameter int CMD_W  = 8;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    typedef enum logic [1:0] {
        TGT_CODE = 2'b00,
        TGT_DATA = 2'b01,
        TGT_INIT = 2'b10,
        TGT_NONE = 2'b11
    } tgt_e;
endpackage

// File: rtl/serprog_sync.sv
// Pin synchronizer and serial-clock edge detector.
// Assumes STAGES >= 2; all three pins see the same latency, so pins that
// change together are seen together in the system domain.
module serprog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic load_pin,
    input  logic sdi_pin,
    output logic sclk_lvl,
    output logic load_lvl,
    output logic sdi_lvl,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] pin_vec;
    logic [NPINS-1:0] lvl;
    logic             sclk_prev;

    assign pin_vec = {sdi_pin, load_pin, sclk_pin};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin_vec[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    assign sclk_lvl = lvl[0];
    assign load_lvl = lvl[1];
    assign sdi_lvl  = lvl[2];

    // Remember the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_lvl;
    end

    assign sclk_rise = sclk_lvl & ~sclk_prev;
    assign sclk_fall = ~sclk_lvl & sclk_prev;
endmodule

// File: rtl/serprog_shifter.sv
// Frame shifter: collects FRAME_W bits MSB first on synchronized rising
// edges, pulses done with the whole frame. Mode pin low clears everything
// and takes priority over a coincident edge.
module serprog_shifter #(
    parameter int FRAME_W = 32,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_lvl,
    input  logic               sclk_rise,
    input  logic               sdi_lvl,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               done,
    output logic [FRAME_W-1:0] frame
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-2:0] sh;

    // Count and shift bits; abort on mode pin low; emit frame on last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (!load_lvl) begin
                bit_cnt <= '0;
                sh      <= '0;
            end else if (sclk_rise) begin
                if (bit_cnt == LAST) begin
                    bit_cnt <= '0;
                    done    <= 1'b1;
                    frame   <= {sh, sdi_lvl};
                    sh      <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    sh      <= {sh[FRAME_W-3:0], sdi_lvl};
                end
            end
        end
    end

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_lvl |=> (bit_cnt == '0) && !done); // R7
    AST_ABORT_BEATS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_lvl && sclk_rise) |=> !done); // R8
    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bit_cnt) == LAST) && (bit_cnt == '0)); // R2
endmodule

// File: rtl/serprog_ctrl.sv
// Frame decoder, memory handshake and serial output driver.
// Assumes mem_ack is a one-cycle pulse answering mem_req, with mem_rdata
// valid in that cycle; mem_busy may stay high after a write is acknowledged.
module serprog_ctrl
    import serprog_pkg::*;
#(
    parameter int CMD_W   = serprog_pkg::CMD_W,
    parameter int ADDR_W  = serprog_pkg::ADDR_W,
    parameter int DATA_W  = serprog_pkg::DATA_W,
    localparam int FRAME_W = CMD_W + ADDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_lvl,
    input  logic               sclk_lvl,
    input  logic               sclk_fall,
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic               done,
    input  logic [FRAME_W-1:0] frame,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_tgt,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_busy,
    output logic               sdo
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] FIELD_START = CNT_W'(FRAME_W - DATA_W);
    localparam logic [CNT_W-1:0] LAST        = CNT_W'(FRAME_W - 1);

    logic              f_wr;
    logic [1:0]        f_tgt;
    logic              f_rsvd;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              f_valid;
    logic              wip;
    logic              accept;
    logic              rd_mode;
    logic [DATA_W-1:0] rbuf;
    logic [CNT_W-1:0]  rd_idx;
    logic              rd_bit;

    assign f_wr    = frame[FRAME_W-1];
    assign f_rsvd  = |frame[FRAME_W-2 : FRAME_W-CMD_W+2];
    assign f_tgt   = frame[FRAME_W-CMD_W +: 2];
    assign f_addr  = frame[DATA_W +: ADDR_W];
    assign f_data  = frame[DATA_W-1:0];
    assign f_valid = (tgt_e'(f_tgt) != TGT_NONE) && !f_rsvd;
    assign wip     = mem_req | mem_busy;
    assign accept  = done && load_lvl && f_valid && !wip;

    // Raise a request for an accepted frame; retire it and keep read data on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_tgt   <= 2'b00;
            mem_addr  <= '0;
            mem_wdata <= '0;
            rd_mode   <= 1'b0;
            rbuf      <= '0;
        end else if (accept) begin
            mem_req   <= 1'b1;
            mem_we    <= f_wr;
            mem_tgt   <= f_tgt;
            mem_addr  <= f_addr;
            mem_wdata <= f_data;
            rd_mode   <= !f_wr;
        end else if (mem_req && mem_ack) begin
            mem_req <= 1'b0;
            if (!mem_we) rbuf <= mem_rdata;
        end
    end

    assign rd_idx = LAST - bit_cnt;
    assign rd_bit = (bit_cnt >= FIELD_START) ? rbuf[rd_idx[IDX_W-1:0]] : 1'b0;

    // Drive the serial output: status in write mode, byte in read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
        end else if (!load_lvl) begin
            sdo <= 1'b0;
        end else if (rd_mode) begin
            if (sclk_fall || (!sclk_lvl && bit_cnt == '0)) sdo <= rd_bit;
        end else if (!sclk_lvl) begin
            sdo <= !wip;
        end
    end

    AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !load_lvl |=> !sdo); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_tgt) && $stable(mem_wdata)); // R4
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req); // R4
    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !f_valid && !mem_req) |=> !mem_req); // R3
    AST_BUSY_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lvl && !rd_mode && !sclk_lvl && (mem_req || mem_busy)) |=> !sdo); // R5
    AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mem_busy && !mem_req) |=> !mem_req); // R9
endmodule

// File: rtl/serprog_port.sv
// Top of the four-wire serial programming port: synchronizer, frame
// shifter and controller. Frame = command, address, data fields, MSB first.
module serprog_port
    import serprog_pkg::*;
#(
    parameter int CMD_W       = serprog_pkg::CMD_W,
    parameter int ADDR_W      = serprog_pkg::ADDR_W,
    parameter int DATA_W      = serprog_pkg::DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_load,
    input  logic              prog_clk,
    input  logic              prog_din,
    output logic              prog_dout,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_tgt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_busy
);
    localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    logic               sclk_lvl, load_lvl, sdi_lvl, sclk_rise, sclk_fall;
    logic [CNT_W-1:0]   bit_cnt;
    logic               done;
    logic [FRAME_W-1:0] frame;

    serprog_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_pin  (prog_clk),
        .load_pin  (prog_load),
        .sdi_pin   (prog_din),
        .sclk_lvl  (sclk_lvl),
        .load_lvl  (load_lvl),
        .sdi_lvl   (sdi_lvl),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    serprog_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_lvl  (load_lvl),
        .sclk_rise (sclk_rise),
        .sdi_lvl   (sdi_lvl),
        .bit_cnt   (bit_cnt),
        .done      (done),
        .frame     (frame)
    );

    serprog_ctrl #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_lvl  (load_lvl),
        .sclk_lvl  (sclk_lvl),
        .sclk_fall (sclk_fall),
        .bit_cnt   (bit_cnt),
        .done      (done),
        .frame     (frame),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_tgt   (mem_tgt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_busy  (mem_busy),
        .sdo       (prog_dout)
    );
endmodule

// File: tb/serprog_port_tb.sv
// Scoreboard bench: frame driver queues expected requests, memory model
// pops and compares them, serial output is checked by the driver.
module serprog_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int ACK_LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_load = 1'b0, prog_clk = 1'b0, prog_din = 1'b0;
    logic        prog_dout;
    logic        mem_req, mem_we;
    logic [1:0]  mem_tgt;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_busy = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int busy_len = 40;
    bit finished = 1'b0;
    logic [26:0] exp_q[$];

    serprog_port u_dut (
        .clk(clk), .rst_n(rst_n), .prog_load(prog_load), .prog_clk(prog_clk),
        .prog_din(prog_din), .prog_dout(prog_dout), .mem_req(mem_req),
        .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_busy(mem_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic we, input logic [1:0] tgt,
                                       input logic [15:0] a, input logic [7:0] d);
        return {we, 5'b00000, tgt, a, d};
    endfunction

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // expected request item: {we, tgt, addr, wdata (0 for reads)}
    task automatic expect_req(input logic [31:0] f);
        exp_q.push_back({f[31], f[25:24], f[23:8], f[31] ? f[7:0] : 8'h00});
    endtask

    task automatic shift(input logic [31:0] f, input int nbits, output logic [31:0] got);
        got = '0;
        for (int i = 31; i >= 32 - nbits; i--) begin
            prog_din = f[i];
            repeat (HALF) @(negedge clk);
            got[i] = prog_dout;
            prog_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            prog_clk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wait_ready(input string tag);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (prog_dout === 1'b1) break;
        end
        chk(tag, {31'b0, prog_dout}, 32'h1);
    endtask

    // Memory model and scoreboard monitor.
    initial begin
        logic [26:0] act, e;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                act = {mem_we, mem_tgt, mem_addr, mem_we ? mem_wdata : 8'h00};
                if (exp_q.size() == 0) begin
                    chk("R2 R3 R9 unexpected request", {5'b0, act}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R2 R3 request fields", {5'b0, act}, {5'b0, e});
                end
                repeat (ACK_LAT) @(negedge clk);
                chk("R4 request held stable", {15'b0, mem_req, mem_addr},
                    {15'b0, 1'b1, act[23:8]});
                mem_rdata = mem_fn(mem_addr);
                mem_ack   = 1'b1;
                if (mem_we) mem_busy = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                chk("R4 request dropped", {31'b0, mem_req}, 32'h0);
                if (mem_busy) begin
                    repeat (busy_len) @(negedge clk);
                    mem_busy = 1'b0;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] f, got;
        repeat (5) @(negedge clk);
        chk("R1 reset output low", {31'b0, prog_dout}, 32'h0);
        chk("R1 reset no request", {31'b0, mem_req}, 32'h0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 idle output low", {31'b0, prog_dout}, 32'h0);

        prog_load = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 ready on entry", {31'b0, prog_dout}, 32'h1);

        // Writes to each target
        f = mk(1'b1, 2'b00, 16'h0123, 8'hA5); expect_req(f); shift(f, 32, got);
        chk("R5 busy after write", {31'b0, prog_dout}, 32'h0);
        wait_ready("R5 ready after write");
        f = mk(1'b1, 2'b01, 16'h0040, 8'h3C); expect_req(f); shift(f, 32, got);
        wait_ready("R5 ready after data write");
        f = mk(1'b1, 2'b10, 16'h0002, 8'h81); expect_req(f); shift(f, 32, got);
        wait_ready("R5 ready after init write");

        // Read then read-out in next frames
        f = mk(1'b0, 2'b01, 16'h1234, 8'h00); expect_req(f); shift(f, 32, got);
        repeat (30) @(negedge clk);
        f = mk(1'b0, 2'b00, 16'h00F0, 8'h00); expect_req(f); shift(f, 32, got);
        chk("R6 read byte", {24'b0, got[7:0]}, {24'b0, mem_fn(16'h1234)});
        chk("R6 low outside data field", {8'b0, got[31:8]}, 32'h0);
        repeat (30) @(negedge clk);
        f = mk(1'b1, 2'b01, 16'h0011, 8'h77); expect_req(f); shift(f, 32, got);
        chk("R6 second read byte", {24'b0, got[7:0]}, {24'b0, mem_fn(16'h00F0)});
        wait_ready("R5 ready after mode change");

        // Invalid target and reserved bit
        f = mk(1'b1, 2'b11, 16'h0777, 8'h11); shift(f, 32, got);
        repeat (20) @(negedge clk);
        chk("R3 target 11 no request", {31'b0, mem_req}, 32'h0);
        chk("R3 mode unchanged", {31'b0, prog_dout}, 32'h1);
        f = mk(1'b0, 2'b01, 16'h0101, 8'h00); f[28] = 1'b1; shift(f, 32, got);
        repeat (20) @(negedge clk);
        chk("R3 reserved bit no request", {31'b0, mem_req}, 32'h0);
        chk("R3 reserved bit mode unchanged", {31'b0, prog_dout}, 32'h1);

        // Mid-frame abort
        f = mk(1'b1, 2'b01, 16'hFFFF, 8'hFF); shift(f, 10, got);
        prog_load = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 output low on abort", {31'b0, prog_dout}, 32'h0);
        prog_load = 1'b1;
        repeat (6) @(negedge clk);
        f = mk(1'b1, 2'b01, 16'h0005, 8'h99); expect_req(f); shift(f, 32, got);
        wait_ready("R7 ready after realigned frame");

        // Abort coincident with last edge
        f = mk(1'b1, 2'b00, 16'h0ABC, 8'h42); shift(f, 31, got);
        prog_din = f[0];
        repeat (HALF) @(negedge clk);
        prog_clk = 1'b1; prog_load = 1'b0;
        repeat (HALF) @(negedge clk);
        prog_clk = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 abort wins over last edge", {31'b0, mem_req}, 32'h0);
        prog_load = 1'b1;
        repeat (6) @(negedge clk);
        f = mk(1'b1, 2'b10, 16'h0003, 8'h5C); expect_req(f); shift(f, 32, got);
        wait_ready("R8 ready after recovery");

        // Frame arriving while store busy
        busy_len = 1500;
        f = mk(1'b1, 2'b01, 16'h0020, 8'hC3); expect_req(f); shift(f, 32, got);
        f = mk(1'b1, 2'b01, 16'h0021, 8'h3C); shift(f, 32, got);
        repeat (10) @(negedge clk);
        chk("R9 no request while busy", {31'b0, mem_req}, 32'h0);
        chk("R9 still busy", {31'b0, prog_dout}, 32'h0);
        wait_ready("R9 ready after long busy");
        busy_len = 40;
        repeat (20) @(negedge clk);

        chk("R2 all expected requests seen", exp_q.size(), 32'h0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule